// File: doc/BRIEF.md
# Serial DAC Input Register Interface

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. A host sends 24-bit frames over three wires: an active-low frame select, a serial clock and a data line. The block brings all three into the system clock domain, shifts the data in on serial clock falling edges and checks each finished frame. A valid frame carries a 16-bit straight-binary code and a 2-bit power mode.

The block holds the code register and the mode register. It gives the analog side the code, a one-cycle load strobe, the mode, and a one-hot switch select that ties the output to ground through 1 k, through 100 k, or leaves it open. A ready flag goes low in power-down, after a return to normal operation, and during a software reset. At power-up the code is preset to zero-scale or midscale, chosen by a build parameter.

Top module: `dacif_top`

## Requirements
- R1: A frame is 24 bits, sent most significant bit first. Each bit is taken on a serial clock falling edge while frame select is low. The frame takes effect only on the 24th such edge. Bits 15:0 are the code, bits 17:16 are the mode, and bits 23:18 must be zero for a write.
- R2: If frame select goes high before the 24th falling edge, the frame is dropped. Code, mode and strobe do not change.
- R3: The mode values are 00 normal, 01 ground through 1 k, 10 ground through 100 k and 11 open. The switch select is bit 0 for 1 k, bit 1 for 100 k and bit 2 for open. It is all zero in normal mode.
- R4: A write with a power-down mode updates only the mode. The code register keeps its value and no load strobe is given.
- R5: After reset the code is 0x0000, or 0x8000 when PRESET_MID is set. The mode is normal.
- R6: A frame of all ones is a software reset. It returns the code to the preset and the mode to normal, with one load strobe. For RST_CYCLES cycles after it, ready is low and any frame that arrives is ignored. A later frame-select abort does not undo it.
- R7: Ready is low in any power-down mode. After a normal-mode write that leaves power-down, ready stays low for WAKE_CYCLES cycles.
- R8: Falling edges after the 24th in the same frame are ignored until frame select goes high and then low again.
- R9: The load strobe is one system-clock cycle wide. It fires once for each normal-mode write and once for each software reset.
- R10: A frame whose bits 23:18 are neither all zero nor all one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sync_n_i | input | 1 | Frame select, active low, asynchronous |
| din_i | input | 1 | Serial data, asynchronous |
| dac_code_o | output | 16 | Code held for the converter |
| load_o | output | 1 | One-cycle update strobe |
| mode_o | output | 2 | Current power mode |
| out_sw_o | output | 3 | One-hot output switch select (1 k, 100 k, open) |
| ready_o | output | 1 | Output settled and usable |

## Verification
A wrong bit count or a misplaced shift would show as a wrong code on the next committed frame. This appears a few cycles after the 24th falling edge. A stale reset-busy or wake counter would show as ready rising too early or too late, and the bench samples ready inside and outside the wait window. A decode error in the mode or command fields would show as an unexpected load strobe, a changed code during power-down, or a non-one-hot switch select. All of these show at the ports within one frame.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam int FRAME_BITS = 24;
    localparam int CODE_W     = 16;
    localparam int MODE_W     = 2;
    localparam int CMD_W      = FRAME_BITS - CODE_W - MODE_W;
    localparam int SW_W       = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN     = 2'b00,
        MODE_PD_1K   = 2'b01,
        MODE_PD_100K = 2'b10,
        MODE_PD_OPEN = 2'b11
    } pmode_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        pmode_e            mode;
        logic [CODE_W-1:0] code;
    } frame_t;

    typedef enum logic [1:0] {
        KIND_WRITE,
        KIND_SOFTRST,
        KIND_BAD
    } kind_e;

    function automatic kind_e classify(input logic [FRAME_BITS-1:0] w);
        if (&w)
            return KIND_SOFTRST;
        else if (w[FRAME_BITS-1 -: CMD_W] == '0)
            return KIND_WRITE;
        else
            return KIND_BAD;
    endfunction

    function automatic logic [SW_W-1:0] switch_sel(input pmode_e m);
        case (m)
            MODE_PD_1K:   return 3'b001;
            MODE_PD_100K: return 3'b010;
            MODE_PD_OPEN: return 3'b100;
            default:      return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter
    import dacif_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_s,
    input  logic   sync_s,
    input  logic   din_s,
    output logic   frm_vld,
    output frame_t frm
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    logic                  sclk_q, sync_q;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] sr;
    logic                  sclk_fall, sync_fall;

    assign sclk_fall = sclk_q & ~sclk_s;
    assign sync_fall = sync_q & ~sync_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            sync_q  <= 1'b1;
            cnt     <= CNT_W'(FRAME_BITS);
            sr      <= '0;
            frm_vld <= 1'b0;
            frm     <= '0;
        end else begin
            sclk_q  <= sclk_s;
            sync_q  <= sync_s;
            frm_vld <= 1'b0;
            if (sync_fall) begin
                cnt <= '0;
            end else if (!sync_s && sclk_fall && cnt != CNT_W'(FRAME_BITS)) begin
                sr  <= {sr[FRAME_BITS-2:0], din_s};
                cnt <= cnt + CNT_W'(1);
                if (cnt == CNT_W'(FRAME_BITS - 1)) begin
                    frm_vld <= 1'b1;
                    frm     <= frame_t'({sr[FRAME_BITS-2:0], din_s});
                end
            end
        end
    end
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
    import dacif_pkg::*;
#(
    parameter bit PRESET_MID  = 1'b0,
    parameter int WAKE_CYCLES = 250,
    parameter int RST_CYCLES  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_vld,
    input  frame_t            frm,
    output logic [CODE_W-1:0] code,
    output pmode_e            mode,
    output logic              load,
    output logic              ready
);
    localparam logic [CODE_W-1:0] PRESET =
        PRESET_MID ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
    localparam int HOLD_MAX = (WAKE_CYCLES > RST_CYCLES) ? WAKE_CYCLES : RST_CYCLES;
    localparam int HW       = $clog2(HOLD_MAX + 1);

    logic [HW-1:0] hold;
    logic          busy;
    kind_e         kind;

    assign kind = classify(frm);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= PRESET;
            mode <= MODE_RUN;
            load <= 1'b0;
            hold <= '0;
            busy <= 1'b0;
        end else begin
            load <= 1'b0;
            if (hold != '0) hold <= hold - HW'(1);
            else            busy <= 1'b0;
            if (frm_vld && !busy) begin
                case (kind)
                    KIND_SOFTRST: begin
                        code <= PRESET;
                        mode <= MODE_RUN;
                        load <= 1'b1;
                        busy <= 1'b1;
                        hold <= HW'(RST_CYCLES);
                    end
                    KIND_WRITE: begin
                        if (frm.mode == MODE_RUN) begin
                            code <= frm.code;
                            load <= 1'b1;
                            if (mode != MODE_RUN) hold <= HW'(WAKE_CYCLES);
                        end
                        mode <= frm.mode;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ready = (mode == MODE_RUN) && (hold == '0) && !busy;
endmodule

// File: rtl/dacif_top.sv
module dacif_top
    import dacif_pkg::*;
#(
    parameter bit PRESET_MID  = 1'b0,
    parameter int WAKE_CYCLES = 250,
    parameter int RST_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sync_n_i,
    input  logic              din_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              load_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [SW_W-1:0]   out_sw_o,
    output logic              ready_o
);
    logic [2:0] pins_s;
    logic       frm_vld;
    frame_t     frm;
    pmode_e     mode_q;

    dacif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sync_n_i, sclk_i, din_i}),
        .q   (pins_s)
    );

    dacif_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (pins_s[1]),
        .sync_s  (pins_s[2]),
        .din_s   (pins_s[0]),
        .frm_vld (frm_vld),
        .frm     (frm)
    );

    dacif_regs #(
        .PRESET_MID  (PRESET_MID),
        .WAKE_CYCLES (WAKE_CYCLES),
        .RST_CYCLES  (RST_CYCLES)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .frm_vld (frm_vld),
        .frm     (frm),
        .code    (dac_code_o),
        .mode    (mode_q),
        .load    (load_o),
        .ready   (ready_o)
    );

    assign mode_o   = mode_q;
    assign out_sw_o = switch_sel(mode_q);
endmodule

// File: rtl/dacif_top_chk.sv
module dacif_top_chk (
    input logic        clk,
    input logic        rst,
    input logic        frm_vld,
    input logic [15:0] dac_code_o,
    input logic        load_o,
    input logic [1:0]  mode_o,
    input logic [2:0]  out_sw_o,
    input logic        ready_o
);
    AST_SW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_sw_o)); // R3

    AST_READY_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (mode_o == 2'b00)); // R7

    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o); // R9

    AST_CODE_MOVES_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_code_o) |-> load_o); // R4

    AST_LOAD_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        load_o |-> $past(frm_vld)); // R1
endmodule

bind dacif_top dacif_top_chk chk (
    .clk        (clk),
    .rst        (rst),
    .frm_vld    (frm_vld),
    .dac_code_o (dac_code_o),
    .load_o     (load_o),
    .mode_o     (mode_o),
    .out_sw_o   (out_sw_o),
    .ready_o    (ready_o)
);

// File: tb/dacif_top_test.sv
module dacif_top_test;
    localparam int WAKE = 40;
    localparam int RSTC = 300;
    localparam int HP   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1, sync_n = 1'b1, din = 1'b0;
    logic [15:0] code;
    logic        load;
    logic [1:0]  mode;
    logic [2:0]  sw;
    logic        ready;

    int checks = 0, errors = 0, loads = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dacif_top #(.PRESET_MID(1'b1), .WAKE_CYCLES(WAKE), .RST_CYCLES(RSTC)) uut (
        .clk (clk), .rst (rst), .sclk_i (sclk), .sync_n_i (sync_n), .din_i (din),
        .dac_code_o (code), .load_o (load), .mode_o (mode), .out_sw_o (sw), .ready_o (ready)
    );

    always @(posedge clk) if (!rst && load) loads++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic send(input logic [23:0] w, input int nbits);
        sclk = 1'b1;
        sync_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            din  = (i < 24) ? w[23-i] : 1'b0;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
            repeat (HP) @(negedge clk);
        end
        sclk = 1'b1;
        repeat (HP) @(negedge clk);
        sync_n = 1'b1;
        repeat (HP) @(negedge clk);
    endtask

    task automatic t_reset;
        chk_eq("R5 preset code", code, 16'h8000);
        chk_eq("R5 preset mode", mode, 2'b00);
        chk_eq("R3 switch normal", sw, 3'b000);
        chk_eq("R7 ready after reset", ready, 1'b1);
        chk_eq("R9 no load at reset", loads, 0);
    endtask

    task automatic t_write;
        int l0 = loads;
        send(24'h00_1234, 24);
        chk_eq("R1 write code", code, 16'h1234);
        chk_eq("R9 one strobe", loads, l0 + 1);
        send(24'h00_FFFF, 24);
        chk_eq("R1 full-scale code", code, 16'hFFFF);
        chk_eq("R1 mode normal", mode, 2'b00);
    endtask

    task automatic t_abort;
        int l0 = loads;
        send(24'h00_5555, 20);
        chk_eq("R2 aborted code", code, 16'hFFFF);
        chk_eq("R2 no strobe", loads, l0);
        send(24'h00_5555, 23);
        chk_eq("R2 23-bit abort", code, 16'hFFFF);
    endtask

    task automatic t_extra;
        int l0 = loads;
        send(24'h00_00A5, 26);
        chk_eq("R8 extra edges ignored", code, 16'h00A5);
        chk_eq("R8 single strobe", loads, l0 + 1);
    endtask

    task automatic t_bad;
        int l0 = loads;
        send(24'h40_7777, 24);
        chk_eq("R10 bad cmd code", code, 16'h00A5);
        chk_eq("R10 bad cmd no strobe", loads, l0);
        chk_eq("R10 bad cmd mode", mode, 2'b00);
    endtask

    task automatic t_powerdown;
        int l0 = loads;
        send(24'h01_1111, 24);
        chk_eq("R3 mode 1k", mode, 2'b01);
        chk_eq("R3 switch 1k", sw, 3'b001);
        chk_eq("R4 code kept", code, 16'h00A5);
        chk_eq("R7 ready low in power-down", ready, 1'b0);
        send(24'h02_2222, 24);
        chk_eq("R3 switch 100k", sw, 3'b010);
        send(24'h03_3333, 24);
        chk_eq("R3 switch open", sw, 3'b100);
        chk_eq("R4 code kept open", code, 16'h00A5);
        chk_eq("R4 no strobe", loads, l0);
    endtask

    task automatic t_wake;
        send(24'h00_4321, 24);
        chk_eq("R1 wake code", code, 16'h4321);
        chk_eq("R3 switch back", sw, 3'b000);
        chk_eq("R7 ready low on wake", ready, 1'b0);
        repeat (WAKE - 10) @(negedge clk);
        chk_eq("R7 ready still low", ready, 1'b0);
        repeat (20) @(negedge clk);
        chk_eq("R7 ready after wake", ready, 1'b1);
    endtask

    task automatic t_soft;
        int l0;
        send(24'h02_0000, 24);
        l0 = loads;
        send(24'hFF_FFFF, 24);
        chk_eq("R6 soft reset code", code, 16'h8000);
        chk_eq("R6 soft reset mode", mode, 2'b00);
        chk_eq("R6 ready low while busy", ready, 1'b0);
        send(24'h00_ABCD, 24);
        chk_eq("R6 frame ignored while busy", code, 16'h8000);
        send(24'h00_1111, 10);
        repeat (150) @(negedge clk);
        chk_eq("R6 code after abort", code, 16'h8000);
        chk_eq("R6 ready after reset", ready, 1'b1);
        chk_eq("R9 soft reset strobe", loads, l0 + 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_abort();
        t_extra();
        t_bad();
        t_powerdown();
        t_wake();
        t_soft();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule